// File: doc/BRIEF.md
# Chip-Select Control Register with Selectable Field Semantics

This block owns one chip-select line of a serial-peripheral controller and the single software register that governs it. Firmware writes the register at byte offset 0x224. A mode bit picks the source of the line. In hardware mode the serial engine's busy flag asserts the line. In software mode the firmware sets the line from a state bit. The line leaves the block through a flop.

A build-time parameter, `VERSION`, selects how the polarity and state bits are read. With `VERSION = 1`, the polarity bit is the level the line takes when asserted, and the state bit is copied straight to the pin. With `VERSION = 2`, the polarity bit is the level the line rests at when deasserted. In that version the state bit means "asserted" when set, so the pin is the XOR of the two bits. Firmware that wants the same pin behaviour must therefore write different values under each version. From reset the line is always deasserted.

Top module: `csel_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, the register reads 0. That selects hardware mode with the polarity bit at 0 and the engine idle. The pin is at the deasserted level: 1 for `VERSION = 1`, 0 for `VERSION = 2`.
- R2: A write with `reg_wr` high and `reg_addr` equal to 0x224 stores three bits: wdata bit 0 (mode: 0 = hardware, 1 = software), bit 1 (state) and bit 12 (polarity). The stored value appears on `reg_rdata` after the write edge. Every other bit of `reg_rdata` reads 0.
- R3: A write to any other address leaves `reg_rdata` and the pin unchanged.
- R4: With `VERSION = 1` in software mode, the pin equals the state bit. A write that updates the register at clock edge N reaches the pin at edge N+1.
- R5: With `VERSION = 2` in software mode, the pin equals the polarity bit XOR the state bit, with the same one-edge latency as R4.
- R6: In hardware mode the asserted level is the polarity bit for `VERSION = 1` and its inverse for `VERSION = 2`. The pin takes the asserted level when `engine_busy` is high and the opposite level otherwise. A busy value sampled at edge N appears on the pin at edge N.
- R7: In software mode `engine_busy` has no effect on the pin.
- R8: In hardware mode with the engine idle, a write of the polarity bit moves the pin to the new deasserted level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| engine_busy | input | 1 | Serial engine busy, drives the line in hardware mode |
| cs_pin | output | 1 | Registered chip-select pin level |

## Verification
A register write becomes visible on `reg_rdata` right after the edge that samples it. It reaches `cs_pin` one edge later, because the pin flop decodes the stored register. A change of `engine_busy` reaches the pin at the first edge that samples it. Each table vector holds its write and busy level across two rising edges and samples at the following falling edge, where every result of that vector has settled. Directed tests then step single edges: they check that `reg_rdata` has moved while the pin still shows its old level, and that the pin moves exactly one edge later. Both versions are instantiated side by side, so every vector checks the two decodes against one register image.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int WORD_W    = 32;
    localparam int MODE_BIT  = 0;
    localparam int STATE_BIT = 1;
    localparam int POL_BIT   = 12;
    localparam logic [WORD_W-1:0] LIVE_MASK =
        (WORD_W'(1) << MODE_BIT) | (WORD_W'(1) << STATE_BIT) | (WORD_W'(1) << POL_BIT);

    typedef struct packed {
        logic pol;
        logic state;
        logic sw_mode;
    } cs_cfg_t;

    localparam cs_cfg_t CFG_RESET = '{pol: 1'b0, state: 1'b0, sw_mode: 1'b0};

    function automatic cs_cfg_t unpack_word(input logic [WORD_W-1:0] w);
        cs_cfg_t c;
        c.pol     = w[POL_BIT];
        c.state   = w[STATE_BIT];
        c.sw_mode = w[MODE_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cfg(input cs_cfg_t c);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[POL_BIT]   = c.pol;
        w[STATE_BIT] = c.state;
        w[MODE_BIT]  = c.sw_mode;
        return w;
    endfunction

    // Level the line takes while asserted, per field semantics version.
    function automatic logic asserted_level(input int ver, input logic pol);
        return (ver == 1) ? pol : ~pol;
    endfunction

    // Pin level for a given configuration and busy flag.
    function automatic logic pin_level(input int ver, input cs_cfg_t c, input logic busy);
        logic lvl;
        if (c.sw_mode)
            lvl = (ver == 1) ? c.state : (c.pol ^ c.state);
        else
            lvl = busy ? asserted_level(ver, c.pol) : ~asserted_level(ver, c.pol);
        return lvl;
    endfunction

endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
    import csel_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CS_OFFSET = ADDR_W'(12'h224)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output cs_cfg_t           cfg_o
);

    logic    hit;
    cs_cfg_t cfg_q;

    assign hit = wr_en && (wr_addr == CS_OFFSET);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (hit)
            cfg_q <= unpack_word(wr_data);
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int VERSION = 1
) (
    input  cs_cfg_t cfg,
    input  logic    busy,
    output logic    pin_d
);

    logic act_lvl;
    logic sw_lvl;

    generate
        if (VERSION == 1) begin : g_v1
            // Polarity is the asserted level; state is the literal pin.
            assign act_lvl = cfg.pol;
            assign sw_lvl  = cfg.state;
        end else begin : g_v2
            // Polarity is the resting level; state set means asserted.
            assign act_lvl = ~cfg.pol;
            assign sw_lvl  = cfg.pol ^ cfg.state;
        end
    endgenerate

    always_comb begin
        if (cfg.sw_mode)
            pin_d = sw_lvl;
        else
            pin_d = busy ? act_lvl : ~act_lvl;
    end

endmodule

// File: rtl/csel_pin_reg.sv
module csel_pin_reg #(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_LEVEL;
        else
            q <= d;
    end

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
    import csel_pkg::*;
#(
    parameter int                VERSION   = 1,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CS_OFFSET = ADDR_W'(12'h224)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              engine_busy,
    output logic              cs_pin
);

    localparam logic RST_PIN = pin_level(VERSION, CFG_RESET, 1'b0);

    cs_cfg_t cfg;
    logic    pin_d;

    csel_regfile #(
        .ADDR_W   (ADDR_W),
        .CS_OFFSET(CS_OFFSET)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .wr_addr(reg_addr),
        .wr_data(reg_wdata),
        .cfg_o  (cfg)
    );

    csel_decode #(
        .VERSION(VERSION)
    ) u_dec (
        .cfg  (cfg),
        .busy (engine_busy),
        .pin_d(pin_d)
    );

    csel_pin_reg #(
        .RST_LEVEL(RST_PIN)
    ) u_pin (
        .clk(clk),
        .rst(rst),
        .d  (pin_d),
        .q  (cs_pin)
    );

    assign reg_rdata = pack_cfg(cfg);

endmodule

// File: rtl/csel_ctrl_chk.sv
module csel_ctrl_chk
    import csel_pkg::*;
#(
    parameter int                VERSION   = 1,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CS_OFFSET = ADDR_W'(12'h224)
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              engine_busy,
    input logic              cs_pin
);

    logic sw, st, pol;
    assign sw  = reg_rdata[MODE_BIT];
    assign st  = reg_rdata[STATE_BIT];
    assign pol = reg_rdata[POL_BIT];

    assert_unused_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LIVE_MASK) == '0);

    assert_foreign_write_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != CS_OFFSET) |=> $stable(reg_rdata));

    assert_sw_literal_R4: assert property (@(posedge clk) disable iff (rst)
        (VERSION == 1 && sw) |=> (cs_pin == $past(st)));

    assert_sw_xor_R5: assert property (@(posedge clk) disable iff (rst)
        (VERSION != 1 && sw) |=> (cs_pin == ($past(pol) ^ $past(st))));

    assert_hw_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (!sw && engine_busy) |=> (cs_pin == ((VERSION == 1) ? $past(pol) : !$past(pol))));

    assert_hw_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!sw && !engine_busy) |=> (cs_pin == ((VERSION == 1) ? !$past(pol) : $past(pol))));

endmodule

bind csel_ctrl csel_ctrl_chk #(
    .VERSION  (VERSION),
    .ADDR_W   (ADDR_W),
    .CS_OFFSET(CS_OFFSET)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .engine_busy(engine_busy),
    .cs_pin     (cs_pin)
);

// File: tb/sim_csel_ctrl.sv
module sim_csel_ctrl;

    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] OFF = 12'h224;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic              busy;
        logic              pin1;
        logic              pin2;
        logic [31:0]       rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, OFF,    32'h0000_0001, 1'b0, 1'b0, 1'b0, 32'h0000_0001}, // R4 R5 sw, state 0
        '{1'b1, OFF,    32'h0000_0003, 1'b0, 1'b1, 1'b1, 32'h0000_0003}, // R4 R5 sw, state 1
        '{1'b1, OFF,    32'h0000_1003, 1'b1, 1'b1, 1'b0, 32'h0000_1003}, // R5 R7 pol 1 state 1
        '{1'b1, OFF,    32'h0000_1001, 1'b1, 1'b0, 1'b1, 32'h0000_1001}, // R7 busy ignored
        '{1'b1, OFF,    32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'h0000_0000}, // R6 hw busy pol 0
        '{1'b0, OFF,    32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000}, // R6 hw idle
        '{1'b1, OFF,    32'h0000_1000, 1'b0, 1'b0, 1'b1, 32'h0000_1000}, // R8 pol flip idle
        '{1'b0, OFF,    32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_1000}, // R6 hw busy pol 1
        '{1'b1, 12'h220,32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 32'h0000_1000}, // R3 other address
        '{1'b1, OFF,    32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 32'h0000_1003}, // R2 masking
        '{1'b1, OFF,    32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000}, // R2 R6 back to hw
        '{1'b1, 12'h228,32'h0000_0001, 1'b0, 1'b1, 1'b0, 32'h0000_0000}  // R3 other address
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr;
    logic [ADDR_W-1:0] reg_addr;
    logic [31:0]       reg_wdata;
    logic              engine_busy;
    logic [31:0]       rd0, rd1;
    logic              pin0, pin1;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk; // 125 MHz

    csel_ctrl #(.VERSION(1), .ADDR_W(ADDR_W), .CS_OFFSET(OFF)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd0), .engine_busy(engine_busy), .cs_pin(pin0)
    );

    csel_ctrl #(.VERSION(2), .ADDR_W(ADDR_W), .CS_OFFSET(OFF)) u1 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd1), .engine_busy(engine_busy), .cs_pin(pin1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edge_to_neg();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; engine_busy = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata v1", rd0, 32'h0);
        check("R1 rdata v2", rd1, 32'h0);
        check("R1 pin v1", {31'b0, pin0}, 32'h1);
        check("R1 pin v2", {31'b0, pin1}, 32'h0);
        rst = 1'b0;
        edge_to_neg();
        check("R1 pin v1 after release", {31'b0, pin0}, 32'h1);
        check("R1 pin v2 after release", {31'b0, pin1}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            reg_wr = VECS[i].wr; reg_addr = VECS[i].addr;
            reg_wdata = VECS[i].wdata; engine_busy = VECS[i].busy;
            @(posedge clk);
            @(negedge clk);
            reg_wr = 1'b0;
            edge_to_neg();
            check($sformatf("R2 R3 vec%0d rdata", i), rd0, VECS[i].rd);
            check($sformatf("R2 R3 vec%0d rdata v2", i), rd1, VECS[i].rd);
            check($sformatf("R4 R6 vec%0d pin v1", i), {31'b0, pin0}, {31'b0, VECS[i].pin1});
            check($sformatf("R5 R6 vec%0d pin v2", i), {31'b0, pin1}, {31'b0, VECS[i].pin2});
        end

        // R4 latency: hw idle (v1 pin 1) -> software state 0
        reg_wr = 1'b1; reg_addr = OFF; reg_wdata = 32'h1;
        edge_to_neg();
        reg_wr = 1'b0;
        check("R2 rdata right after write edge", rd0, 32'h1);
        check("R4 pin holds one edge", {31'b0, pin0}, 32'h1);
        edge_to_neg();
        check("R4 pin after second edge", {31'b0, pin0}, 32'h0);

        // R5 latency: state set, v2 pin goes 0 -> 1
        reg_wr = 1'b1; reg_wdata = 32'h3;
        edge_to_neg();
        reg_wr = 1'b0;
        check("R5 pin holds one edge", {31'b0, pin1}, 32'h0);
        edge_to_neg();
        check("R5 pin after second edge", {31'b0, pin1}, 32'h1);

        // R6 busy latency in hardware mode, pol 0
        reg_wr = 1'b1; reg_wdata = 32'h0;
        edge_to_neg();
        reg_wr = 1'b0;
        edge_to_neg();
        engine_busy = 1'b1;
        edge_to_neg();
        check("R6 busy v1 same edge", {31'b0, pin0}, 32'h0);
        check("R6 busy v2 same edge", {31'b0, pin1}, 32'h1);
        engine_busy = 1'b0;
        edge_to_neg();
        check("R6 idle v1", {31'b0, pin0}, 32'h1);

        // R1 reset mid-run from software-asserted state
        reg_wr = 1'b1; reg_wdata = 32'h1003;
        edge_to_neg();
        reg_wr = 1'b0;
        edge_to_neg();
        rst = 1'b1;
        edge_to_neg();
        check("R1 rdata after mid reset", rd0, 32'h0);
        check("R1 pin v1 after mid reset", {31'b0, pin0}, 32'h1);
        check("R1 pin v2 after mid reset", {31'b0, pin1}, 32'h0);
        rst = 1'b0;
        edge_to_neg();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule